// File: doc/BRIEF.md
# Frame Delimiter Error Checker

This block watches a receive stream that has already been split into start-of-frame markers, end-of-frame markers and data words, one indication of each per clock cycle. It tracks only the order of the delimiters and whether each frame carried at least one data word. When it sees a violation, it raises a one-cycle error pulse. It also presents a registered frame-active status that downstream logic can use to qualify the words it collects.

Three kinds of violation are flagged:
- a start marker arriving while a frame is already open;
- an end marker arriving while no frame is open;
- a frame that closes without any data word.

Idle cycles inside a frame are legal and do not close the frame. A start marker inside an open frame is flagged, but the frame stays open and its contents count again from that marker. The block does not decode line symbols and does not check any CRC.

Within a single cycle the indications are evaluated in this order: start marker, then data word, then end marker. So one cycle with all three set is a legal single-word frame.

Top module: `frame_delim_checker`

## Requirements
- R1: After reset is released, `frameErr` and `frameActive` are both 0.
- R2: A cycle with `sofIn`=1 and `eofIn`=0 makes `frameActive` 1 from the next cycle on. A cycle with `eofIn`=1 makes `frameActive` 0 in the next cycle.
- R3: A cycle with `sofIn`=1 while `frameActive` is 1 makes `frameErr` 1 in the next cycle. The frame then restarts: data words seen before that marker no longer count for the frame.
- R4: A cycle with `eofIn`=1 and `sofIn`=0 while `frameActive` is 0 makes `frameErr` 1 in the next cycle.
- R5: A cycle with `eofIn`=1 that closes an open frame makes `frameErr` 1 in the next cycle when no data word was seen since that frame's start marker. The count includes data words in the start cycle and in the end cycle.
- R6: Cycles with `sofIn`, `eofIn` and `dataIn` all 0 leave `frameActive` unchanged and give `frameErr` 0 in the next cycle. A frame with idle cycles between its data words and its end marker is legal.
- R7: A cycle with `sofIn`, `dataIn` and `eofIn` all 1 while no frame is open is a legal single-word frame: the next cycle shows `frameErr` 0 and `frameActive` 0.
- R8: `frameErr` is 1 for exactly one cycle per offending cycle. It returns to 0 in the cycle after a non-offending cycle.
- R9: `dataIn` while no frame is open and `sofIn` is 0 raises no error and changes no state. Such words do not count toward the next frame.
- R10: A cycle holding several violations at once, such as a start marker in an open frame together with an end marker and no data, gives a single one-cycle pulse and leaves `frameActive` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sofIn | input | 1 | Start-of-frame marker seen this cycle |
| eofIn | input | 1 | End-of-frame marker seen this cycle |
| dataIn | input | 1 | A data word is present this cycle |
| frameErr | output | 1 | One-cycle pulse, the cycle after an offending delimiter |
| frameActive | output | 1 | Registered status: a frame is open |

## Verification
The bench targets the cases where the within-cycle ordering matters:
- A start, data and end marker in one cycle must pass; a design that checked the end marker before the data word would flag it as an empty frame.
- A data word carried only in the start cycle or only in the end cycle must count. A data word before a repeated start marker, or outside any frame, must not count; a design that kept its data-seen flag across the restart would miss the empty frame that follows.
- Back-to-back stray end markers must give back-to-back pulses that then stop.
- A design that stretched the pulse, or let a second start marker close the frame, would show the wrong value one cycle later.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic {
    OUT_OF_FRAME = 1'b0,
    IN_FRAME     = 1'b1
  } frameState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearSeen;   // frame boundary: reload the data-seen flag
    logic markSeen;    // a data word belongs to the open frame
    logic raiseErr;    // this cycle holds a delimiter violation
  } fdcStrobe_t;

endpackage

// File: rtl/fdc_ctrl.sv
module fdc_ctrl
  import fdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sofIn,
  input  logic       eofIn,
  input  logic       dataIn,
  input  logic       seenData,
  output fdcStrobe_t strb,
  output logic       frameActive
);

  frameState_e state, stateNext;

  logic inNow;
  logic openAfterSof;
  logic dupSof;
  logic dupEof;
  logic dataSoFar;
  logic emptyEnd;

  always_comb begin
    inNow        = (state == IN_FRAME);
    // evaluation order inside one cycle: SOF, then data, then EOF
    openAfterSof = inNow || sofIn;
    dupSof       = sofIn && inNow;
    dupEof       = eofIn && !openAfterSof;
    dataSoFar    = dataIn || (seenData && !sofIn);
    emptyEnd     = eofIn && openAfterSof && !dataSoFar;

    if (eofIn)      stateNext = OUT_OF_FRAME;
    else if (sofIn) stateNext = IN_FRAME;
    else            stateNext = state;

    strb.clearSeen = sofIn || eofIn;
    strb.markSeen  = dataIn && openAfterSof && !eofIn;
    strb.raiseErr  = dupSof || dupEof || emptyEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= OUT_OF_FRAME;
    else       state <= stateNext;
  end

  assign frameActive = inNow;

  AST_SEEN_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> !seenData);  // R9

endmodule

// File: rtl/fdc_dpath.sv
module fdc_dpath
  import fdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  fdcStrobe_t strb,
  output logic       seenData,
  output logic       frameErr
);

  logic seenNext;

  always_comb begin
    if (strb.clearSeen) seenNext = strb.markSeen;
    else                seenNext = seenData || strb.markSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenData <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      seenData <= seenNext;
      frameErr <= strb.raiseErr;
    end
  end

  AST_MARK_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.markSeen && !strb.clearSeen) |=> seenData);  // R6

endmodule

// File: rtl/frame_delim_checker.sv
module frame_delim_checker
  import fdc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sofIn,
  input  logic eofIn,
  input  logic dataIn,
  output logic frameErr,
  output logic frameActive
);

  fdcStrobe_t strb;
  logic       seenData;

  fdc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sofIn      (sofIn),
    .eofIn      (eofIn),
    .dataIn     (dataIn),
    .seenData   (seenData),
    .strb       (strb),
    .frameActive(frameActive)
  );

  fdc_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .seenData (seenData),
    .frameErr (frameErr)
  );

  AST_SOF_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (sofIn && !eofIn) |=> frameActive);  // R2
  AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    eofIn |=> !frameActive);  // R2
  AST_DOUBLE_SOF: assert property (@(posedge clk) disable iff (!rstN)
    (sofIn && frameActive) |=> frameErr);  // R3
  AST_DOUBLE_EOF: assert property (@(posedge clk) disable iff (!rstN)
    (eofIn && !sofIn && !frameActive) |=> frameErr);  // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!sofIn && !eofIn && !dataIn) |=> ($stable(frameActive) && !frameErr));  // R6
  AST_SINGLE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (sofIn && eofIn && dataIn && !frameActive) |=> (!frameErr && !frameActive));  // R7
  AST_NO_DELIM_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (!sofIn && !eofIn) |=> !frameErr);  // R8

endmodule

// File: tb/frame_delim_checker_tb.sv
`timescale 1ns/1ps
module frame_delim_checker_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofIn = 1'b0, eofIn = 1'b0, dataIn = 1'b0;
  logic frameErr, frameActive;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  frame_delim_checker u_dut (
    .clk(clk), .rstN(rstN), .sofIn(sofIn), .eofIn(eofIn), .dataIn(dataIn),
    .frameErr(frameErr), .frameActive(frameActive)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", what, got, exp, $time);
    end
  endtask

  // apply one cycle of inputs (called at a falling edge), return at the next falling edge
  task automatic cyc(input logic s, input logic e, input logic d);
    sofIn = s; eofIn = e; dataIn = d;
    @(negedge clk);
  endtask

  task automatic expect2(input logic err, input logic act, input string tag);
    chk(frameErr, err, {tag, " frameErr"});
    chk(frameActive, act, {tag, " frameActive"});
  endtask

  task automatic idle(); cyc(0, 0, 0); endtask

  task automatic t_reset();
    expect2(0, 0, "R1 reset");
  endtask

  task automatic t_normal();
    cyc(1, 0, 0); expect2(0, 1, "R2 sof opens");
    cyc(0, 0, 1); expect2(0, 1, "R2 data");
    cyc(0, 1, 1); expect2(0, 0, "R2 eof closes");
    cyc(1, 0, 1); expect2(0, 1, "R5 data in sof cycle");
    cyc(0, 1, 0); expect2(0, 0, "R5 sof-cycle data counts");
    cyc(1, 0, 0); cyc(0, 1, 1); expect2(0, 0, "R5 eof-cycle data counts");
  endtask

  task automatic t_idle_inside();
    cyc(1, 0, 0); cyc(0, 0, 1);
    idle(); expect2(0, 1, "R6 idle in frame");
    idle(); expect2(0, 1, "R6 idle in frame 2");
    cyc(0, 1, 0); expect2(0, 0, "R6 eof after idle");
  endtask

  task automatic t_empty();
    cyc(1, 0, 0); idle();
    cyc(0, 1, 0); expect2(1, 0, "R5 empty frame");
    idle(); expect2(0, 0, "R8 pulse ends");
    cyc(1, 1, 0); expect2(1, 0, "R5 sof+eof no data");
    idle();
  endtask

  task automatic t_double_sof();
    cyc(1, 0, 0); cyc(0, 0, 1);
    cyc(1, 0, 0); expect2(1, 1, "R3 second sof");
    cyc(0, 1, 0); expect2(1, 0, "R3 restart drops old data");
    cyc(1, 0, 1); cyc(1, 0, 0); expect2(1, 1, "R3 sof on sof");
    cyc(0, 0, 1); expect2(0, 1, "R8 pulse one cycle");
    cyc(0, 1, 0); expect2(0, 0, "R3 restarted frame ok");
  endtask

  task automatic t_double_eof();
    cyc(1, 0, 1); cyc(0, 1, 0); expect2(0, 0, "R4 good frame");
    cyc(0, 1, 0); expect2(1, 0, "R4 stray eof");
    cyc(0, 1, 1); expect2(1, 0, "R8 consecutive stray eof");
    idle(); expect2(0, 0, "R8 pulse stops");
  endtask

  task automatic t_single();
    cyc(1, 1, 1); expect2(0, 0, "R7 single-word frame");
    cyc(1, 1, 1); expect2(0, 0, "R7 back-to-back single");
  endtask

  task automatic t_data_outside();
    cyc(0, 0, 1); expect2(0, 0, "R9 data outside");
    cyc(0, 0, 1); expect2(0, 0, "R9 data outside 2");
    cyc(1, 0, 0); cyc(0, 1, 0); expect2(1, 0, "R9 outside data not counted");
    idle();
  endtask

  task automatic t_coincident();
    cyc(1, 0, 1);
    cyc(1, 1, 0); expect2(1, 0, "R10 double sof and empty end");
    idle(); expect2(0, 0, "R10 single pulse");
  endtask

  initial begin
    #20000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_idle_inside();
    t_empty();
    t_double_sof();
    t_double_eof();
    t_single();
    t_data_outside();
    t_coincident();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule